// File: doc/BRIEF.md
# Processor-to-System Bus Demultiplexer

This block turns the shared address/data pins of a small processor running without an external bus controller into a separate system bus. The processor puts the low address byte on shared lines and the top four address bits on shared address/status lines during the first clock of a bus cycle, and pulses an address strobe at the same time. The block follows the address through while the strobe is high and holds it once the strobe drops. The shared lines are then free to carry data, and the system bus keeps a steady 20-bit address.

Data passes through a two-way buffer. A direction input selects processor-to-system or system-to-processor flow, and an active-low enable connects or isolates the two sides. Three basic control lines (the I/O-versus-memory select and the read and write strobes) are decoded into four active-low system commands. When the processor gives the bus to another master, the address and command drivers are released.

The system side is modelled as value-plus-enable pairs rather than as tristate nets. An enable of 0 means that side is in high impedance.

Top module: `sysbus_demux`

## Requirements
- R1: While rst_n is low, with the address strobe low, sys_addr reads 0 and all four commands are inactive (1).
- R2: While ale is 1 during a memory access (io_sel=0), sys_addr equals {cpu_as_i, cpu_a_hi_i, cpu_ad_i} in the same cycle, with cpu_as_i as bits 19..16, cpu_a_hi_i as bits 15..8 and cpu_ad_i as bits 7..0.
- R3: While ale is 0 during a memory access, sys_addr holds the address present at the last rising clock edge at which ale was 1. Later changes on the shared lines have no effect on it.
- R4: With den_n=0 and dt_r=1, sys_d_oe=1, sys_d_o equals cpu_ad_i and cpu_ad_oe=0.
- R5: With den_n=0 and dt_r=0, cpu_ad_oe=1, cpu_ad_o equals sys_d_i and sys_d_oe=0.
- R6: With den_n=1, both sys_d_oe and cpu_ad_oe are 0, whatever dt_r is.
- R7: With bus_grant=0 and io_sel=0, rd_n=0 with wr_n=1 asserts only mem_rd_n (0), and wr_n=0 with rd_n=1 asserts only mem_wr_n (0).
- R8: With bus_grant=0 and io_sel=1, rd_n=0 with wr_n=1 asserts only io_rd_n (0), and wr_n=0 with rd_n=1 asserts only io_wr_n (0).
- R9: At most one command is ever low. When rd_n and wr_n are both 0, or both 1, no command is asserted.
- R10: While io_sel=1, sys_addr bits 19..16 read 0 and bits 15..0 follow R2 and R3.
- R11: When bus_grant=1, sys_addr_oe=0, cmd_oe=0 and all four commands are 1. When bus_grant=0, sys_addr_oe=1 and cmd_oe=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the address strobe |
| rst_n | input | 1 | Active-low reset, clears the held address |
| ale | input | 1 | Address strobe, high while the shared lines carry address |
| io_sel | input | 1 | 1 = I/O access, 0 = memory access |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| dt_r | input | 1 | Data direction, 1 = toward system, 0 = toward processor |
| den_n | input | 1 | Data buffer enable, active low |
| bus_grant | input | 1 | Bus handed to another master |
| cpu_ad_i | input | 8 | Shared low address / data lines, as seen from the processor |
| cpu_a_hi_i | input | 8 | Address bits 15..8 |
| cpu_as_i | input | 4 | Shared top address / status lines |
| cpu_ad_o | output | 8 | Data driven back toward the processor |
| cpu_ad_oe | output | 1 | Drive enable for cpu_ad_o |
| sys_addr | output | 20 | System address |
| sys_addr_oe | output | 1 | Drive enable for sys_addr |
| sys_d_i | input | 8 | Data arriving from the system bus |
| sys_d_o | output | 8 | Data driven onto the system bus |
| sys_d_oe | output | 1 | Drive enable for sys_d_o |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| cmd_oe | output | 1 | Drive enable for the four commands |

## Verification
Directed cases load a memory address and an I/O address with the strobe held across a clock edge. The shared lines are then overwritten while the strobe is low, which separates a true hold from a simple pass-through and shows whether the top bits are masked for I/O. Every combination of the select and the two strobes is applied, including both strobes low, with and without the bus granted away, so that each of the four commands is told apart from its neighbours. Random patterns then vary strobe timing, direction, enable and data on both sides at once. This confirms that only the selected side is driven and that the held address follows only the strobe.

// File: rtl/sysbus_demux_pkg.sv
package sysbus_demux_pkg;

    typedef struct packed {
        logic mem_rd_n;
        logic mem_wr_n;
        logic io_rd_n;
        logic io_wr_n;
    } bus_cmd_t;

    localparam bus_cmd_t CMD_NONE = 4'b1111;

endpackage

// File: rtl/sysbus_addr_hold.sv
module sysbus_addr_hold #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] held;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ale) begin
            st_d.held = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Strobe high: pass the live lines straight through; low: the stored copy
    assign addr_o = ale ? addr_i : st_q.held;

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && $past(!ale)) |-> $stable(addr_o));

    // R3
    addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (addr_o == $past(addr_i)));

endmodule

// File: rtl/sysbus_data_xcvr.sv
module sysbus_data_xcvr #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              den_n,
    input  logic              dt_r,
    input  logic [DATA_W-1:0] cpu_i,
    input  logic [DATA_W-1:0] sys_i,
    output logic [DATA_W-1:0] cpu_o,
    output logic              cpu_oe,
    output logic [DATA_W-1:0] sys_o,
    output logic              sys_oe
);

    logic to_sys, to_cpu;

    always_comb begin
        to_sys = !den_n &&  dt_r;
        to_cpu = !den_n && !dt_r;
    end

    // One gated lane per data bit, each direction driving zeros when idle
    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
        assign sys_o[b] = to_sys & cpu_i[b];
        assign cpu_o[b] = to_cpu & sys_i[b];
    end

    assign sys_oe = to_sys;
    assign cpu_oe = to_cpu;

    // R6
    xcvr_one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys_oe && cpu_oe));

    // R4
    xcvr_fwd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_oe |-> (sys_o == cpu_i));

    // R5
    xcvr_rev_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_oe |-> (cpu_o == sys_i));

endmodule

// File: rtl/sysbus_cmd_decode.sv
module sysbus_cmd_decode
    import sysbus_demux_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     io_sel,
    input  logic     rd_n,
    input  logic     wr_n,
    input  logic     bus_grant,
    output bus_cmd_t cmd
);

    logic legal;

    always_comb begin
        legal = (rd_n != wr_n) && !bus_grant;
        cmd   = CMD_NONE;
        if (legal) begin
            if (!rd_n) begin
                if (io_sel) cmd.io_rd_n  = 1'b0;
                else        cmd.mem_rd_n = 1'b0;
            end else begin
                if (io_sel) cmd.io_wr_n  = 1'b0;
                else        cmd.mem_wr_n = 1'b0;
            end
        end
    end

    // R9
    cmd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cmd));

    // R9
    cmd_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !wr_n) |-> (cmd == CMD_NONE));

    // R8
    cmd_io_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> (cmd.mem_rd_n && cmd.mem_wr_n));

endmodule

// File: rtl/sysbus_demux.sv
module sysbus_demux
    import sysbus_demux_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int STAT_W = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ale,
    input  logic                              io_sel,
    input  logic                              rd_n,
    input  logic                              wr_n,
    input  logic                              dt_r,
    input  logic                              den_n,
    input  logic                              bus_grant,
    input  logic [DATA_W-1:0]                 cpu_ad_i,
    input  logic [ADDR_W-DATA_W-STAT_W-1:0]   cpu_a_hi_i,
    input  logic [STAT_W-1:0]                 cpu_as_i,
    output logic [DATA_W-1:0]                 cpu_ad_o,
    output logic                              cpu_ad_oe,
    output logic [ADDR_W-1:0]                 sys_addr,
    output logic                              sys_addr_oe,
    input  logic [DATA_W-1:0]                 sys_d_i,
    output logic [DATA_W-1:0]                 sys_d_o,
    output logic                              sys_d_oe,
    output logic                              mem_rd_n,
    output logic                              mem_wr_n,
    output logic                              io_rd_n,
    output logic                              io_wr_n,
    output logic                              cmd_oe
);

    localparam int IO_W = ADDR_W - STAT_W;

    logic [ADDR_W-1:0] live_addr;
    logic [ADDR_W-1:0] held_addr;
    bus_cmd_t          cmd;

    assign live_addr = {cpu_as_i, cpu_a_hi_i, cpu_ad_i};

    sysbus_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .ale    (ale),
        .addr_i (live_addr),
        .addr_o (held_addr)
    );

    sysbus_data_xcvr #(.DATA_W(DATA_W)) u_xcvr (
        .clk    (clk),
        .rst_n  (rst_n),
        .den_n  (den_n),
        .dt_r   (dt_r),
        .cpu_i  (cpu_ad_i),
        .sys_i  (sys_d_i),
        .cpu_o  (cpu_ad_o),
        .cpu_oe (cpu_ad_oe),
        .sys_o  (sys_d_o),
        .sys_oe (sys_d_oe)
    );

    sysbus_cmd_decode u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_sel    (io_sel),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .bus_grant (bus_grant),
        .cmd       (cmd)
    );

    // I/O space is 16 bits wide: the top status-shared bits are cleared
    always_comb begin
        sys_addr = held_addr;
        if (io_sel) begin
            sys_addr[ADDR_W-1:IO_W] = '0;
        end
    end

    assign sys_addr_oe = !bus_grant;
    assign cmd_oe      = !bus_grant;
    assign mem_rd_n    = cmd.mem_rd_n;
    assign mem_wr_n    = cmd.mem_wr_n;
    assign io_rd_n     = cmd.io_rd_n;
    assign io_wr_n     = cmd.io_wr_n;

    // R11
    grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && !sys_addr_oe));

    // R10
    io_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> (sys_addr[ADDR_W-1:IO_W] == '0));

    // R2
    pass_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (sys_addr[IO_W-1:0] == live_addr[IO_W-1:0]));

endmodule

// File: tb/sysbus_demux_bench.sv
`timescale 1ns/1ps
module sysbus_demux_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0, io_sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic        dt_r = 1'b0, den_n = 1'b1, bus_grant = 1'b0;
    logic [7:0]  cpu_ad_i = '0, cpu_a_hi_i = '0, sys_d_i = '0;
    logic [3:0]  cpu_as_i = '0;
    logic [7:0]  cpu_ad_o, sys_d_o;
    logic        cpu_ad_oe, sys_d_oe, sys_addr_oe, cmd_oe;
    logic [19:0] sys_addr;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    logic [19:0] model_held = '0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    sysbus_demux u_sysbus_demux (
        .clk(clk), .rst_n(rst_n), .ale(ale), .io_sel(io_sel), .rd_n(rd_n),
        .wr_n(wr_n), .dt_r(dt_r), .den_n(den_n), .bus_grant(bus_grant),
        .cpu_ad_i(cpu_ad_i), .cpu_a_hi_i(cpu_a_hi_i), .cpu_as_i(cpu_as_i),
        .cpu_ad_o(cpu_ad_o), .cpu_ad_oe(cpu_ad_oe), .sys_addr(sys_addr),
        .sys_addr_oe(sys_addr_oe), .sys_d_i(sys_d_i), .sys_d_o(sys_d_o),
        .sys_d_oe(sys_d_oe), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .cmd_oe(cmd_oe)
    );

    function automatic logic [19:0] exp_addr(input logic strobe, input logic io,
                                             input logic [19:0] live, input logic [19:0] held);
        logic [19:0] a;
        a = strobe ? live : held;
        if (io) a[19:16] = 4'h0;
        return a;
    endfunction

    // {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}
    function automatic logic [3:0] exp_cmd(input logic io, input logic rd, input logic wr,
                                           input logic grant);
        if (grant || (rd == wr)) return 4'b1111;
        if (!rd) return io ? 4'b1101 : 4'b0111;
        return io ? 4'b1110 : 4'b1011;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [19:0] live;
        logic [3:0]  ec;
        string       tag;
        live = {cpu_as_i, cpu_a_hi_i, cpu_ad_i};
        tag = ale ? (io_sel ? "R10" : "R2") : (io_sel ? "R10" : "R3");
        check(tag, sys_addr, exp_addr(ale, io_sel, live, model_held));
        ec  = exp_cmd(io_sel, rd_n, wr_n, bus_grant);
        tag = bus_grant ? "R11" : ((rd_n == wr_n) ? "R9" : (io_sel ? "R8" : "R7"));
        check(tag, {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, ec);
        check("R11", {sys_addr_oe, cmd_oe}, {2{!bus_grant}});
        if (den_n) begin
            check("R6", {sys_d_oe, cpu_ad_oe}, 2'b00);
        end else if (dt_r) begin
            check("R4", {sys_d_oe, cpu_ad_oe, sys_d_o}, {2'b10, cpu_ad_i});
        end else begin
            check("R5", {sys_d_oe, cpu_ad_oe, cpu_ad_o}, {2'b01, sys_d_i});
        end
    endtask

    // Inputs are already set after a falling edge; check, then pass a rising edge
    task automatic step();
        #1;
        check_all();
        @(posedge clk);
        if (ale && rst_n) model_held = {cpu_as_i, cpu_a_hi_i, cpu_ad_i};
        @(negedge clk);
    endtask

    task automatic set_addr(input logic [19:0] a);
        {cpu_as_i, cpu_a_hi_i, cpu_ad_i} = a;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        set_addr(20'h3C3C3);
        repeat (3) @(negedge clk);
        check("R1", sys_addr, 20'h0);
        check("R1", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'b1111);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R3: memory address passes, then holds while lines carry data
        ale = 1'b1; io_sel = 1'b0; set_addr(20'hABCDE);
        step();
        ale = 1'b0; cpu_ad_i = 8'h55; cpu_a_hi_i = 8'h11; cpu_as_i = 4'h2;
        rd_n = 1'b0; den_n = 1'b0; dt_r = 1'b0; sys_d_i = 8'h9A;
        step();
        check("R3", sys_addr, 20'hABCDE);
        check("R7", mem_rd_n, 1'b0);
        rd_n = 1'b1; wr_n = 1'b0; dt_r = 1'b1;
        step();
        check("R7", mem_wr_n, 1'b0);

        // R10, R8: I/O address with top bits masked
        wr_n = 1'b1; den_n = 1'b1;
        ale = 1'b1; io_sel = 1'b1; set_addr(20'hF1234);
        step();
        ale = 1'b0; cpu_ad_i = 8'hEE; rd_n = 1'b0;
        step();
        check("R10", sys_addr, 20'h01234);
        check("R8", io_rd_n, 1'b0);
        rd_n = 1'b1; wr_n = 1'b0;
        step();
        check("R8", io_wr_n, 1'b0);

        // R9: both strobes low
        rd_n = 1'b0; wr_n = 1'b0;
        step();
        // R11: bus handed away
        rd_n = 1'b0; wr_n = 1'b1; bus_grant = 1'b1;
        step();
        check("R11", {sys_addr_oe, cmd_oe, io_rd_n}, 3'b001);
        bus_grant = 1'b0;
        // R6 with both directions
        den_n = 1'b1; dt_r = 1'b0; step();
        den_n = 1'b1; dt_r = 1'b1; step();

        for (int i = 0; i < 3000; i++) begin
            ale       = ($urandom % 3) == 0;
            io_sel    = $urandom % 2;
            rd_n      = $urandom % 2;
            wr_n      = $urandom % 2;
            dt_r      = $urandom % 2;
            den_n     = $urandom % 2;
            bus_grant = ($urandom % 5) == 0;
            set_addr($urandom);
            sys_d_i   = $urandom;
            step();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule